// File: doc/BRIEF.md
# Pin Activity Monitor with Search Qualifier

This block watches two general-purpose input pins of a small bus slave. Each pin is first synchronized to the system clock, then passed through a glitch filter. A change of level counts as an event only if the new level lasts longer than a minimum pulse width. Every accepted event, rising or falling, sets a sticky per-channel activity flag. The flags stay set until a clear strobe arrives or power-on reset is asserted.

From the flags, or from the synchronized pin levels, the block forms one qualifier bit called `search_match_o`. The slave's enumeration logic uses this bit to decide whether to take part in a conditional search. Software programs three things through a byte-wide register port:

- a channel selection mask;
- a per-channel polarity;
- a source-select bit and a combine-type bit, which pick an "any selected channel matches" or an "every selected channel matches" reduction.

The register port has no back-pressure. A write is taken in the cycle that `reg_wr_i` is high, and read data is a combinational function of `reg_addr_i`. No stream interface crosses the block edge.

Top module: `pio_watch`

## Requirements
- R1: Reading address 0x0222 returns the activity flags, with bit n holding the flag of channel n and bits 7:2 reading 0.
- R2: Writing any value to 0x0222 leaves the activity flags unchanged.
- R3: A change of the synchronized pin level that persists for MIN_PW+1 clocks or more sets that channel's flag, for both rising and falling changes. A pulse of MIN_PW clocks or fewer is ignored.
- R4: Once set, a flag holds until `latch_clr_i` is pulsed, which zeroes all flags on the next clock. Power-on reset also zeroes them.
- R5: Address 0x0223 is the read/write selection mask, with bit n including channel n. Bits 7:2 read 0 and ignore writes, and the mask resets to 0x00.
- R6: Address 0x0224 is a read/write mode register with these fields. Bits 1:0 are the channel polarities. Bit 4 selects the source: 0 takes the activity flags, 1 takes the synchronized pin levels. Bit 5 selects the combine type: 0 means any, 1 means all. All other bits read 0, and the register resets to 0x00.
- R7: With combine type 0, `search_match_o` is 1 exactly when at least one selected channel's signal equals its polarity bit.
- R8: With combine type 1, `search_match_o` is 1 exactly when every selected channel's signal equals its polarity bit.
- R9: With an all-zero mask, `search_match_o` is 0 in both combine types.
- R10: Reads of any address other than 0x0222, 0x0223 and 0x0224 return 0x00.
- R11: A pin level already present when power-on reset is released is not an event and sets no flag.
- R12: With the pin source selected, `search_match_o` reflects a pin change on the second rising clock edge after that change, and not on the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_i | input | 2 | Monitored pins, asynchronous to clk |
| latch_clr_i | input | 1 | One-cycle strobe that clears all activity flags |
| reg_wr_i | input | 1 | Register write enable |
| reg_addr_i | input | 16 | Register address for reads and writes |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| search_match_o | output | 1 | Conditional-search qualifier |

## Verification
A stuck or wrongly set activity flag is visible at once through a read of 0x0222. It also surfaces through `search_match_o` as soon as that channel is selected with the flag source.

A filter counter that restarts at the wrong time shows up as one of two faults at the R3 boundary: a MIN_PW-clock pulse that latches, or a MIN_PW+1-clock pulse that does not. Either is visible a few clocks after the pulse ends.

A corrupted mask or mode field shows in the read-back on the very next cycle. It also shows as a wrong qualifier for the first pin or flag pattern that separates the any and all reductions.

// File: rtl/pio_watch_pkg.sv
package pio_watch_pkg;
  localparam int REG_AW = 16;
  localparam int REG_DW = 8;

  localparam logic [REG_AW-1:0] ADDR_FLAGS = 16'h0222;
  localparam logic [REG_AW-1:0] ADDR_MASK  = 16'h0223;
  localparam logic [REG_AW-1:0] ADDR_MODE  = 16'h0224;

  // bit positions inside the mode register
  localparam int MODE_SRC_BIT = 4;
  localparam int MODE_ALL_BIT = 5;

  typedef struct packed {
    logic all_mode;  // 1: every selected channel must match
    logic pin_src;   // 1: synchronized pin levels, 0: activity flags
  } mode_t;
endpackage

// File: rtl/pio_chan_filter.sv
module pio_chan_filter #(
  parameter int MIN_PW = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_i,
  input  logic clr_i,
  output logic level_o,
  output logic flag_o
);
  localparam int CW = (MIN_PW < 1) ? 1 : $clog2(MIN_PW + 1);

  logic          sync_a, sync_b;
  logic [2:0]    warm;
  logic          armed;
  logic          held_lvl;
  logic [CW-1:0] cnt;
  logic          differs, accept;

  assign armed   = warm[2];
  assign differs = sync_b != held_lvl;
  assign accept  = armed && differs && (cnt == CW'(MIN_PW));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      warm   <= '0;
    end else begin
      sync_a <= pin_i;
      sync_b <= sync_a;
      warm   <= {warm[1:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      held_lvl <= 1'b0;
      cnt      <= '0;
    end else if (!armed) begin
      held_lvl <= sync_b;   // adopt the level found at reset release
      cnt      <= '0;
    end else if (!differs) begin
      cnt <= '0;            // level went back: restart the width count
    end else if (accept) begin
      held_lvl <= sync_b;
      cnt      <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      flag_o <= 1'b0;
    else if (clr_i)  flag_o <= 1'b0;
    else if (accept) flag_o <= 1'b1;
  end

  assign level_o = sync_b;
endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_watch_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic [NUM_CH-1:0] flags_i,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] pol_o,
  output mode_t             mode_o,
  output logic [REG_DW-1:0] rdata_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mask_o <= '0;
      pol_o  <= '0;
      mode_o <= '0;
    end else if (wr_i) begin
      if (addr_i == ADDR_MASK) mask_o <= wdata_i[NUM_CH-1:0];
      if (addr_i == ADDR_MODE) begin
        pol_o           <= wdata_i[NUM_CH-1:0];
        mode_o.pin_src  <= wdata_i[MODE_SRC_BIT];
        mode_o.all_mode <= wdata_i[MODE_ALL_BIT];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_FLAGS: rdata_o[NUM_CH-1:0] = flags_i;
      ADDR_MASK:  rdata_o[NUM_CH-1:0] = mask_o;
      ADDR_MODE: begin
        rdata_o[NUM_CH-1:0]  = pol_o;
        rdata_o[MODE_SRC_BIT] = mode_o.pin_src;
        rdata_o[MODE_ALL_BIT] = mode_o.all_mode;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pio_qualify.sv
module pio_qualify
  import pio_watch_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic [NUM_CH-1:0] flags_i,
  input  logic [NUM_CH-1:0] level_i,
  input  logic [NUM_CH-1:0] mask_i,
  input  logic [NUM_CH-1:0] pol_i,
  input  mode_t             mode_i,
  output logic              match_o
);
  logic [NUM_CH-1:0] chan_sig, hit;
  logic any_hit, all_hit;

  assign chan_sig = mode_i.pin_src ? level_i : flags_i;
  assign hit      = ~(chan_sig ^ pol_i) & mask_i;
  assign any_hit  = |hit;
  assign all_hit  = (|mask_i) && (hit == mask_i);
  assign match_o  = mode_i.all_mode ? all_hit : any_hit;
endmodule

// File: rtl/pio_watch.sv
module pio_watch
  import pio_watch_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int MIN_PW = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic              latch_clr_i,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic              search_match_o
);
  logic [NUM_CH-1:0] flag_vec, level_vec, mask_q, pol_q;
  mode_t             mode_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pio_chan_filter #(.MIN_PW(MIN_PW)) u_filt (
      .clk     (clk),
      .por_n   (por_n),
      .pin_i   (pin_i[c]),
      .clr_i   (latch_clr_i),
      .level_o (level_vec[c]),
      .flag_o  (flag_vec[c])
    );
  end

  pio_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk     (clk),
    .por_n   (por_n),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .flags_i (flag_vec),
    .mask_o  (mask_q),
    .pol_o   (pol_q),
    .mode_o  (mode_q),
    .rdata_o (reg_rdata_o)
  );

  pio_qualify #(.NUM_CH(NUM_CH)) u_qual (
    .flags_i (flag_vec),
    .level_i (level_vec),
    .mask_i  (mask_q),
    .pol_i   (pol_q),
    .mode_i  (mode_q),
    .match_o (search_match_o)
  );
endmodule

// File: rtl/pio_watch_chk.sv
module pio_watch_chk
  import pio_watch_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              por_n,
  input logic              clr_i,
  input logic [REG_AW-1:0] addr_i,
  input logic [REG_DW-1:0] rdata_i,
  input logic [NUM_CH-1:0] flags_i,
  input logic [NUM_CH-1:0] mask_i,
  input logic              match_i
);
  // R4: flags never drop without a clear strobe
  a_r4_sticky: assert property (@(posedge clk) disable iff (!por_n)
    !clr_i |=> (($past(flags_i) & ~flags_i) == '0));

  // R4: a clear strobe empties every flag on the next clock
  a_r4_clear: assert property (@(posedge clk) disable iff (!por_n)
    clr_i |=> (flags_i == '0));

  // R5: mask read-back has no bits above the channel count
  a_r5_mask_upper: assert property (@(posedge clk) disable iff (!por_n)
    (addr_i == ADDR_MASK) |-> (rdata_i[REG_DW-1:NUM_CH] == '0));

  // R9: nothing selected means no response
  a_r9_empty_mask: assert property (@(posedge clk) disable iff (!por_n)
    (mask_i == '0) |-> !match_i);

  // R10: unmapped addresses read zero
  a_r10_unmapped: assert property (@(posedge clk) disable iff (!por_n)
    (addr_i != ADDR_FLAGS && addr_i != ADDR_MASK && addr_i != ADDR_MODE)
      |-> (rdata_i == '0));
endmodule

bind pio_watch pio_watch_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk     (clk),
  .por_n   (por_n),
  .clr_i   (latch_clr_i),
  .addr_i  (reg_addr_i),
  .rdata_i (reg_rdata_o),
  .flags_i (flag_vec),
  .mask_i  (mask_q),
  .match_i (search_match_o)
);

// File: tb/pio_watch_bench.sv
module pio_watch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_PW     = 4;
  localparam int NUM_CH     = 2;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic [1:0]  pins = 2'b10;
  logic        clr = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] addr = 16'h0;
  logic [7:0]  wdata = 8'h0;
  logic [7:0]  rdata;
  logic        match;

  int n_chk = 0;
  int n_fail = 0;

  // bench model state
  logic [1:0] m_flag = 2'b00, m_mask = 2'b00, m_pol = 2'b00;
  logic       m_src = 1'b0, m_all = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_watch #(.NUM_CH(NUM_CH), .MIN_PW(MIN_PW)) u_pio_watch (
    .clk            (clk),
    .por_n          (por_n),
    .pin_i          (pins),
    .latch_clr_i    (clr),
    .reg_wr_i       (wr),
    .reg_addr_i     (addr),
    .reg_wdata_i    (wdata),
    .reg_rdata_o    (rdata),
    .search_match_o (match)
  );

  function automatic logic f_match(input logic [1:0] fl, input logic [1:0] pn,
                                   input logic [1:0] mk, input logic [1:0] pl,
                                   input logic src, input logic all);
    logic [1:0] sig, hit;
    sig = src ? pn : fl;
    hit = ~(sig ^ pl) & mk;
    if (mk == 2'b00) return 1'b0;
    return all ? (hit == mk) : (hit != 2'b00);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    if (a == 16'h0223) m_mask = d[1:0];
    if (a == 16'h0224) begin m_pol = d[1:0]; m_src = d[4]; m_all = d[5]; end
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic match_chk(input string tag);
    logic e;
    #1;
    e = f_match(m_flag, pins, m_mask, m_pol, m_src, m_all);
    chk(match == e, tag, match, e);
  endtask

  task automatic set_pins(input logic [1:0] nv);
    @(negedge clk);
    m_flag = m_flag | (pins ^ nv);
    pins = nv;
    idle(MIN_PW + 5);
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    m_flag = 2'b00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(3);
    por_n = 1'b1;
    idle(10);

    // R11 / R1: pin1 high across reset release is not an event
    rd_chk(16'h0222, 8'h00, "R11 R1 flags after reset");
    rd_chk(16'h0223, 8'h00, "R5 mask reset value");
    rd_chk(16'h0224, 8'h00, "R6 mode reset value");
    match_chk("R9 empty mask after reset");

    // R10
    rd_chk(16'h0225, 8'h00, "R10 unmapped 0x0225");
    rd_chk(16'h0221, 8'h00, "R10 unmapped 0x0221");
    rd_chk(16'h0000, 8'h00, "R10 unmapped 0x0000");

    // R5 / R6 field write masking
    wr_reg(16'h0223, 8'hFF);
    rd_chk(16'h0223, 8'h03, "R5 mask upper bits");
    wr_reg(16'h0224, 8'hFF);
    rd_chk(16'h0224, 8'h33, "R6 mode field layout");
    wr_reg(16'h0223, 8'h00);
    wr_reg(16'h0224, 8'h00);

    // R3: pulse of exactly MIN_PW clocks is filtered out
    @(negedge clk); pins[0] = 1'b1;
    repeat (MIN_PW) @(negedge clk);
    pins[0] = 1'b0;
    idle(12);
    rd_chk(16'h0222, 8'h00, "R3 short pulse ignored");

    // R3: MIN_PW+1 clocks is accepted (rising)
    @(negedge clk); pins[0] = 1'b1;
    repeat (MIN_PW + 1) @(negedge clk);
    pins[0] = 1'b0;
    idle(12);
    m_flag[0] = 1'b1;
    rd_chk(16'h0222, 8'h01, "R3 qualified rising pulse");

    // R3: falling change on channel 1
    set_pins(2'b00);
    rd_chk(16'h0222, 8'h03, "R3 falling change ch1");

    // R2: write to flag register has no effect
    wr_reg(16'h0222, 8'h00);
    rd_chk(16'h0222, 8'h03, "R2 flags read-only");

    // R4: clear
    pulse_clr();
    rd_chk(16'h0222, 8'h00, "R4 clear strobe");
    idle(5);
    rd_chk(16'h0222, 8'h00, "R4 flags stay clear");

    // R8 / R7 on flag source, flags = 00
    wr_reg(16'h0223, 8'h03);
    wr_reg(16'h0224, 8'h20);          // pol 00, AND
    @(negedge clk); match_chk("R8 all flags equal polarity");
    wr_reg(16'h0224, 8'h21);          // pol 01, AND
    @(negedge clk); match_chk("R8 one channel mismatches");
    wr_reg(16'h0224, 8'h01);          // pol 01, OR
    @(negedge clk); match_chk("R7 one channel matches");
    wr_reg(16'h0224, 8'h03);          // pol 11, OR
    @(negedge clk); match_chk("R7 no channel matches");

    // R12: pin source latency
    wr_reg(16'h0223, 8'h01);
    wr_reg(16'h0224, 8'h10);          // pins, pol 00, OR
    @(negedge clk); match_chk("R12 pin source before change");
    pins[0] = 1'b1;
    @(negedge clk); #1;
    chk(match == 1'b1, "R12 unchanged after one edge", match, 1);
    @(negedge clk); #1;
    chk(match == 1'b0, "R12 follows pin after two edges", match, 0);
    m_flag[0] = 1'b1;
    idle(MIN_PW + 5);
    rd_chk(16'h0222, 8'h01, "R3 flag from pin test");

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom_range(0, 4);
      case (op)
        0, 1: set_pins(2'($urandom_range(0, 3)));
        2: wr_reg(16'h0223, 8'($urandom_range(0, 255)));
        3: wr_reg(16'h0224, 8'($urandom_range(0, 255)));
        default: pulse_clr();
      endcase
      @(negedge clk);
      match_chk((m_all ? "R8 random" : (m_mask == 2'b00 ? "R9 random" : "R7 random")));
      rd_chk(16'h0222, {6'b0, m_flag}, "R1 random flags");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule